// File: doc/BRIEF.md
# Ones-Counting Decimation Filter

This block turns a 1-bit oversampled delta-sigma stream into 8-bit words. It counts the 1 bits in consecutive, back-to-back windows of 256 clock cycles. Counting over a window works as a running-average (sinc) low-pass filter that also drops the rate by 256. Each finished count is read as a binary fraction, result/256, which equals the ones density of the stream. For example, 128 ones in a window gives 0.5, and 207 ones gives about 0.81.

A free-running frame divider counts down from 255 to 0 and starts again at 255. The cycle in which it reads 0 is the frame cycle. In that cycle the bit present on the input is the last bit of the window. The total, including that bit, is loaded into the output register, and the accumulator restarts from zero. An active-high synchronous clear starts a new conversion: it zeroes the accumulator and the result, and it reloads the divider with 255.

The result is a stream with a valid strobe and no ready input. A word is offered for exactly one cycle and then held until the next frame overwrites it. The window is fixed in clock cycles, so the block cannot stall, and a consumer that needs a word must take it in the strobe cycle or before the next one.

Top module: `dsd_decimator`

## Requirements
- R1: While `clr_i` is high at a rising edge, `result_o` becomes 0 and `result_valid_o` becomes 0. After `clr_i` falls, the next window begins with the first rising edge at which `clr_i` is low.
- R2: The first result after `clr_i` is released appears exactly 256 rising edges later. After that, a result appears every 256 edges, and `result_valid_o` stays low at every other edge.
- R3: `result_o` equals the number of edges in the window at which `ds_bit_i` was 1. Edges at which `ds_bit_i` is 0 do not change the count.
- R4: A window in which all 256 bits are 1 yields 255 (all ones), not 0.
- R5: `result_valid_o` is high for exactly one cycle, and that cycle is the first one in which the new word is present on `result_o`.
- R6: `result_o` holds its value at every edge that is not a frame edge.
- R7: If `clr_i` is high at a frame edge, clear wins: the result becomes 0, no strobe is issued, and the pending count is discarded.
- R8: Consecutive windows are contiguous. The bit at the frame edge belongs to the ending window, and the bit at the following edge is the first bit of the next window. No bit is lost and no bit is counted twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one stream bit is sampled per rising edge |
| clr_i | input | 1 | Active-high synchronous clear; starts a new conversion |
| ds_bit_i | input | 1 | Oversampled 1-bit stream |
| result_o | output | 8 | Ones count of the last window (fraction result/256) |
| result_valid_o | output | 1 | One-cycle strobe marking a new word on result_o |

## Verification
Clear and frame capture can land on the same edge. The bench provokes this by raising clear on the 256th edge of a window whose 255 earlier bits were all 1. It then checks that the result reads 0 with no strobe, and that the next full window produces its own correct count at exactly 256 edges. A second clear, placed in the middle of a window, checks that the frame boundary realigns to the release of clear. The bench also drives single 1 bits at the first and last positions of a window to show where the window boundary falls.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  localparam int unsigned DSD_WIN_LOG2 = 8;
endpackage

// File: rtl/dsd_frame_div.sv
module dsd_frame_div #(
  parameter int unsigned W = 8
) (
  input  logic clk_i,
  input  logic clr_i,
  output logic frame_o
);
  logic [W-1:0] div_q;

  always_ff @(posedge clk_i) begin
    if (clr_i) div_q <= '1;
    else       div_q <= div_q - 1'b1;
  end

  assign frame_o = (div_q == '0);

  a_r2_div_step: assert property (@(posedge clk_i) disable iff (clr_i)
    (div_q != '0) |=> (div_q == $past(div_q) - 1'b1));
  a_r2_div_reload: assert property (@(posedge clk_i) disable iff (clr_i)
    (div_q == '0) |=> (div_q == '1));
endmodule

// File: rtl/dsd_ones_acc.sv
module dsd_ones_acc #(
  parameter int unsigned CW = 9
) (
  input  logic          clk_i,
  input  logic          clr_i,
  input  logic          frame_i,
  input  logic          ds_bit_i,
  output logic [CW-1:0] sum_o
);
  logic [CW-1:0] cnt_q;

  assign sum_o = cnt_q + {{(CW-1){1'b0}}, ds_bit_i};

  always_ff @(posedge clk_i) begin
    if (clr_i || frame_i) cnt_q <= '0;
    else                  cnt_q <= sum_o;
  end

  a_r3_count_up: assert property (@(posedge clk_i) disable iff (clr_i)
    (!frame_i && ds_bit_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r3_count_hold: assert property (@(posedge clk_i) disable iff (clr_i)
    (!frame_i && !ds_bit_i) |=> $stable(cnt_q));
  a_r8_restart: assert property (@(posedge clk_i) disable iff (clr_i)
    frame_i |=> (cnt_q == '0));
  a_r4_no_wrap: assert property (@(posedge clk_i) disable iff (clr_i)
    (cnt_q[CW-1] == 1'b0));
endmodule

// File: rtl/dsd_result_reg.sv
module dsd_result_reg #(
  parameter int unsigned RW = 8,
  parameter int unsigned CW = 9
) (
  input  logic          clk_i,
  input  logic          clr_i,
  input  logic          frame_i,
  input  logic [CW-1:0] sum_i,
  output logic [RW-1:0] result_o,
  output logic          valid_o
);
  logic [RW-1:0] clip;

  generate
    if (CW > RW) begin : g_sat
      always_comb clip = (|sum_i[CW-1:RW]) ? {RW{1'b1}} : sum_i[RW-1:0];
    end else begin : g_pass
      always_comb clip = RW'(sum_i);
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (clr_i) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= frame_i;
      if (frame_i) result_o <= clip;
    end
  end

  a_r6_hold: assert property (@(posedge clk_i) disable iff (clr_i)
    !frame_i |=> $stable(result_o));
  a_r5_strobe_on_frame: assert property (@(posedge clk_i) disable iff (clr_i)
    frame_i |=> valid_o);
  a_r5_single: assert property (@(posedge clk_i) disable iff (clr_i)
    valid_o |=> !valid_o);
  a_r1_clear_state: assert property (@(posedge clk_i)
    clr_i |=> (result_o == '0 && !valid_o));
endmodule

// File: rtl/dsd_decimator.sv
module dsd_decimator #(
  parameter int unsigned WIN_LOG2 = dsd_pkg::DSD_WIN_LOG2
) (
  input  logic                clk_i,
  input  logic                clr_i,
  input  logic                ds_bit_i,
  output logic [WIN_LOG2-1:0] result_o,
  output logic                result_valid_o
);
  localparam int unsigned CW = WIN_LOG2 + 1;

  logic          frame;
  logic [CW-1:0] sum;

  dsd_frame_div #(.W(WIN_LOG2)) u_div (
    .clk_i(clk_i), .clr_i(clr_i), .frame_o(frame)
  );

  dsd_ones_acc #(.CW(CW)) u_acc (
    .clk_i(clk_i), .clr_i(clr_i), .frame_i(frame),
    .ds_bit_i(ds_bit_i), .sum_o(sum)
  );

  dsd_result_reg #(.RW(WIN_LOG2), .CW(CW)) u_res (
    .clk_i(clk_i), .clr_i(clr_i), .frame_i(frame), .sum_i(sum),
    .result_o(result_o), .valid_o(result_valid_o)
  );

  a_r7_clear_wins: assert property (@(posedge clk_i)
    (clr_i && frame) |=> (!result_valid_o && result_o == '0));
endmodule

// File: tb/dsd_decimator_tb.sv
module dsd_decimator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 256;

  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       ds_bit = 1'b0;
  logic [7:0] result;
  logic       valid;

  int checks = 0;
  int errors = 0;
  int prev_exp = 0;
  bit finished = 0;

  dsd_decimator u_dut (
    .clk_i(clk), .clr_i(clr), .ds_bit_i(ds_bit),
    .result_o(result), .result_valid_o(valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // modes: 0 zeros, 1 ones, 2 alternate, 3 random density arg/256,
  //        4 single one at position arg, 5 all ones except position arg
  function automatic logic gen_bit(input int mode, input int i, input int arg);
    case (mode)
      0: return 1'b0;
      1: return 1'b1;
      2: return logic'(i % 2);
      3: return logic'(($urandom % 256) < arg);
      4: return logic'(i == arg);
      default: return logic'(i != arg);
    endcase
  endfunction

  function automatic int expect_word(input int ones);
    return (ones > 255) ? 255 : ones;
  endfunction

  task automatic run_window(input int mode, input int arg, input string tag);
    int ones = 0;
    int strobe_bad = 0;
    int hold_bad = 0;
    int exp;
    for (int i = 0; i < WIN; i++) begin
      logic b;
      b = gen_bit(mode, i, arg);
      ds_bit = b;
      ones += int'(b);
      @(negedge clk);
      if (i < WIN - 1) begin
        if (valid) strobe_bad++;
        if (int'(result) != prev_exp) hold_bad++;
      end
    end
    exp = expect_word(ones);
    check(valid === 1'b1, "R5 strobe at new word", int'(valid), 1);
    check(int'(result) == exp, tag, int'(result), exp);
    check(strobe_bad == 0, "R2 no strobe inside window", strobe_bad, 0);
    check(hold_bad == 0, "R6 result held inside window", hold_bad, 0);
    prev_exp = exp;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(result == 8'd0 && valid == 1'b0, "R1 reset state", int'(result), 0);
    clr = 1'b0;

    run_window(0, 0, "R3 all-zero window");
    run_window(1, 0, "R4 all-one window saturates");
    run_window(5, 255, "R8 last bit zero gives 255");
    run_window(5, 0, "R8 first bit zero gives 255");
    run_window(4, 255, "R8 single one at frame edge");
    run_window(4, 0, "R8 single one at window start");
    run_window(2, 0, "R3 alternating gives half");
    run_window(3, 207, "R3 random density 207");
    for (int k = 0; k < 6; k++) begin
      int d;
      d = int'($urandom % 257);
      run_window(3, d, "R3 random density");
    end

    // R7: clear on the frame edge of a window of ones
    for (int i = 0; i < WIN; i++) begin
      ds_bit = 1'b1;
      if (i == WIN - 1) clr = 1'b1;
      @(negedge clk);
    end
    clr = 1'b0;
    check(result == 8'd0 && valid == 1'b0, "R7 clear beats capture",
          int'(result), 0);
    prev_exp = 0;
    run_window(4, 3, "R2 first window after clear on frame edge");

    // R1: clear in the middle of a window realigns the frame
    for (int i = 0; i < 100; i++) begin
      ds_bit = 1'b1;
      @(negedge clk);
    end
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check(result == 8'd0 && valid == 1'b0, "R1 mid-window clear", int'(result), 0);
    prev_exp = 0;
    run_window(4, 0, "R1 window realigned to clear release");
    run_window(1, 0, "R4 saturation after realign");

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end
endmodule